// File: doc/BRIEF.md
# DMA Completion Timeout Watchdog

This block guards one outstanding bus-master DMA command. A start pulse, given when the command goes to the drive, arms a countdown of twice the command wait period. If the completion interrupt is handled first, a cancel pulse disarms everything. If the countdown runs out first, the block samples the live DMA status byte and picks one outcome. It can wait longer, report a fault, or ask for a bus reset.

Every command gets one free extension. When the status shows the engine still active, or an interrupt pending, the block waits one more command period and uses up the extension. When the status shows the premature-expiry pattern, the block also waits one more command period but keeps the extension. Once the extension is spent, the next expiry is final: the block raises an error together with a request to retry the command in programmed I/O mode. The drive protocol and the reset sequence itself belong to the surrounding controller.

Top module: `dma_wdog`

## Requirements
- R1: After reset all three outputs are low and no outcome appears until a start pulse is given.
- R2: A start pulse arms the timer. The first expiry outcome appears exactly 2*CMD_WAIT clock edges after the edge that sampled start.
- R3: If status bits 4 and 3 are both set at an expiry while the extension is still available, the block waits CMD_WAIT more edges and keeps the extension. This pattern takes precedence over the error bit (status 0x1A is treated the same as 0x18).
- R4: If status bit 1 is set at an expiry with the extension available, and the R3 pattern is absent, the block pulses err_o alone and disarms. Bit 1 takes precedence over bits 0 and 2.
- R5: If status bit 0 or bit 2 is set at an expiry with the extension available, and neither bit 1 nor the R3 pattern is present, the block waits CMD_WAIT more edges and uses up the extension.
- R6: If none of bits 0 to 4 applies at an expiry with the extension available, the block pulses bus_rst_o alone and disarms.
- R7: An expiry after the extension has been used up always pulses err_o and pio_retry_o together and disarms, whatever the status byte holds.
- R8: A cancel pulse disarms the timer and restores a clean state, and no outcome follows. When cancel and start arrive in the same cycle, cancel wins. A start after a cancel gets a fresh extension.
- R9: Each outcome is a pulse lasting one clock cycle. A start while the timer is armed restarts the full 2*CMD_WAIT countdown with a fresh extension.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command issued; arms or re-arms the timer |
| cancel_i | input | 1 | Completion handled; disarms and clears |
| dma_stat_i | input | STAT_W | Live DMA status byte |
| err_o | output | 1 | Error outcome pulse |
| bus_rst_o | output | 1 | Bus reset request pulse |
| pio_retry_o | output | 1 | Retry-in-PIO pulse, given together with err_o |

## Verification
The hardest case to reach is proving that a premature expiry leaves the extension unused. From the ports, a kept extension looks the same as a spent one until some later expiry. The stimulus therefore holds the busy pattern through three expiries, then clears the status just before the fourth. The outcome at that fourth expiry must be a bus reset, not a final error. The same sequence is repeated with the error bit added to the busy pattern, and a cancel issued midway through an extension is followed by a new start to show that the allowance comes back.

// File: rtl/dmawd_pkg.sv
package dmawd_pkg;
   typedef enum logic [1:0] {
      VERD_EARLY   = 2'd0,
      VERD_FAULT   = 2'd1,
      VERD_EXTEND  = 2'd2,
      VERD_UNKNOWN = 2'd3
   } verdict_e;
endpackage

// File: rtl/dmawd_sync.sv
module dmawd_sync #(
   parameter int STAT_W = 8,
   parameter int STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] d_i,
   output logic [STAT_W-1:0] q_o
);
   initial begin
      assert (STAGES >= 0 && STAGES <= 4) else $error("STAGES out of range");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAT_W-1:0] stg_q [STAGES];
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)      stg_q[i] <= '0;
               else if (i == 0) stg_q[i] <= d_i;
               else             stg_q[i] <= stg_q[(i > 0) ? i-1 : 0];
            end
         end
         assign q_o = stg_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/dmawd_classify.sv
module dmawd_classify
   import dmawd_pkg::*;
#(
   parameter int STAT_W   = 8,
   parameter int BIT_ACT  = 0,
   parameter int BIT_ERR  = 1,
   parameter int BIT_IRQ  = 2,
   parameter int BIT_PR_A = 3,
   parameter int BIT_PR_B = 4
) (
   input  logic [STAT_W-1:0] stat_i,
   output verdict_e          verdict_o
);
   initial begin
      assert (STAT_W > BIT_ACT && STAT_W > BIT_ERR && STAT_W > BIT_IRQ &&
              STAT_W > BIT_PR_A && STAT_W > BIT_PR_B)
         else $error("status bit position beyond STAT_W");
   end

   logic early_pair;
   logic unused_bits;
   assign early_pair  = stat_i[BIT_PR_A] & stat_i[BIT_PR_B];
   assign unused_bits = ^stat_i;

   always_comb begin
      if (early_pair)                            verdict_o = VERD_EARLY;
      else if (stat_i[BIT_ERR])                  verdict_o = VERD_FAULT;
      else if (stat_i[BIT_ACT] | stat_i[BIT_IRQ]) verdict_o = VERD_EXTEND;
      else                                       verdict_o = VERD_UNKNOWN;
   end
endmodule

// File: rtl/dmawd_timer.sv
module dmawd_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             run_i,
   output logic             expired_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt_q <= '0;
      else if (clr_i)                    cnt_q <= '0;
      else if (load_i)                   cnt_q <= load_val_i;
      else if (run_i && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign expired_o = run_i && (cnt_q == '0);

   // R2: an armed timer steps down by one each edge until it expires
   a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !load_i && !clr_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/dmawd_ctrl.sv
module dmawd_ctrl
   import dmawd_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter logic [CNT_W-1:0] LONG_LD  = '1,
   parameter logic [CNT_W-1:0] SHORT_LD = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             cancel_i,
   input  logic             expired_i,
   input  verdict_e         verdict_i,
   output logic             armed_o,
   output logic             clr_o,
   output logic             load_o,
   output logic [CNT_W-1:0] load_val_o,
   output logic             err_o,
   output logic             bus_rst_o,
   output logic             pio_retry_o
);
   logic armed_q, ride_q;
   logic armed_d, ride_d;
   logic f_err, f_rst, f_pio;
   logic err_q, rst_q, pio_q;

   always_comb begin
      armed_d    = armed_q;
      ride_d     = ride_q;
      load_o     = 1'b0;
      load_val_o = LONG_LD;
      f_err      = 1'b0;
      f_rst      = 1'b0;
      f_pio      = 1'b0;
      if (cancel_i) begin
         armed_d = 1'b0;
         ride_d  = 1'b0;
      end else if (start_i) begin
         armed_d = 1'b1;
         ride_d  = 1'b1;
         load_o  = 1'b1;
      end else if (expired_i) begin
         if (!ride_q) begin
            f_err   = 1'b1;
            f_pio   = 1'b1;
            armed_d = 1'b0;
         end else begin
            unique case (verdict_i)
               VERD_EARLY: begin
                  load_o     = 1'b1;
                  load_val_o = SHORT_LD;
               end
               VERD_EXTEND: begin
                  load_o     = 1'b1;
                  load_val_o = SHORT_LD;
                  ride_d     = 1'b0;
               end
               VERD_FAULT: begin
                  f_err   = 1'b1;
                  armed_d = 1'b0;
                  ride_d  = 1'b0;
               end
               default: begin
                  f_rst   = 1'b1;
                  armed_d = 1'b0;
                  ride_d  = 1'b0;
               end
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         ride_q  <= 1'b0;
         err_q   <= 1'b0;
         rst_q   <= 1'b0;
         pio_q   <= 1'b0;
      end else begin
         armed_q <= armed_d;
         ride_q  <= ride_d;
         err_q   <= f_err;
         rst_q   <= f_rst;
         pio_q   <= f_pio;
      end
   end

   assign armed_o     = armed_q;
   assign clr_o       = cancel_i;
   assign err_o       = err_q;
   assign bus_rst_o   = rst_q;
   assign pio_retry_o = pio_q;

   // R7: a final outcome only follows a spent extension
   a_r7_final_after_spent: assert property (@(posedge clk) disable iff (!rst_n)
      pio_q |-> !$past(ride_q));
   // R7: the PIO retry always travels with the error
   a_r7_pio_with_err: assert property (@(posedge clk) disable iff (!rst_n)
      pio_q |-> err_q);
   // R4: a plain fault needs the extension still in hand
   a_r4_fault_had_ride: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !pio_q) |-> $past(ride_q));
   // R6: a bus reset request never coincides with an error
   a_r6_reset_alone: assert property (@(posedge clk) disable iff (!rst_n)
      rst_q |-> !err_q);
   // R8: nothing follows a cancel
   a_r8_cancel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_i |=> !(err_q || rst_q || pio_q));
   // R9: outcomes last one cycle
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q || rst_q) |=> !(err_q || rst_q));
endmodule

// File: rtl/dma_wdog.sv
module dma_wdog
   import dmawd_pkg::*;
#(
   parameter int CMD_WAIT    = 1000,
   parameter int STAT_W      = 8,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              cancel_i,
   input  logic [STAT_W-1:0] dma_stat_i,
   output logic              err_o,
   output logic              bus_rst_o,
   output logic              pio_retry_o
);
   localparam int CNT_W = $clog2(2 * CMD_WAIT);
   localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(2 * CMD_WAIT - 1);
   localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(CMD_WAIT - 1);

   initial begin
      assert (CMD_WAIT >= 2) else $error("CMD_WAIT must be at least 2");
      assert (STAT_W >= 5)   else $error("STAT_W must hold bits 0..4");
   end

   logic [STAT_W-1:0] stat_s;
   verdict_e          verdict;
   logic              armed, clr, load, expired;
   logic [CNT_W-1:0]  load_val;

   dmawd_sync #(.STAT_W(STAT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(dma_stat_i), .q_o(stat_s));

   dmawd_classify #(.STAT_W(STAT_W)) u_cls (
      .stat_i(stat_s), .verdict_o(verdict));

   dmawd_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .load_i(load),
      .load_val_i(load_val), .run_i(armed), .expired_o(expired));

   dmawd_ctrl #(.CNT_W(CNT_W), .LONG_LD(LONG_LD), .SHORT_LD(SHORT_LD)) u_ctl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cancel_i(cancel_i),
      .expired_i(expired), .verdict_i(verdict), .armed_o(armed),
      .clr_o(clr), .load_o(load), .load_val_o(load_val),
      .err_o(err_o), .bus_rst_o(bus_rst_o), .pio_retry_o(pio_retry_o));

   // R1: no outcome while disarmed and not expiring
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !start_i) |=> !(err_o || bus_rst_o || pio_retry_o));
endmodule

// File: tb/dma_wdog_tb.sv
module dma_wdog_tb;
   localparam int W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, cancel = 1'b0;
   logic [7:0] stat = 8'h00;
   logic err, brst, pio;
   int n_chk = 0, n_bad = 0, cyc = 0;

   always #2.5 clk = ~clk;

   dma_wdog #(.CMD_WAIT(W), .STAT_W(8), .SYNC_STAGES(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .cancel_i(cancel),
      .dma_stat_i(stat), .err_o(err), .bus_rst_o(brst), .pio_retry_o(pio));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         n_bad = n_bad + 1;
         n_chk = n_chk + 1;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cyc);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic kick();
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic pulse_cancel(input bit with_start);
      cancel = 1'b1;
      start  = with_start;
      @(posedge clk);
      @(negedge clk);
      cancel = 1'b0;
      start  = 1'b0;
   endtask

   // samples after each of maxk edges; records first outcome edge and code {err,rst,pio}
   task automatic watch(input int maxk, output int hit, output logic [2:0] v, output int np);
      hit = 0; v = 3'b000; np = 0;
      for (int k = 1; k <= maxk; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (err || brst || pio) begin
            np++;
            if (hit == 0) begin
               hit = k;
               v = {err, brst, pio};
            end
         end
      end
   endtask

   task automatic t_reset();
      int h, n; logic [2:0] v;
      chk({err, brst, pio} == 3'b000, "R1 outputs after reset", int'({err, brst, pio}), 0);
      watch(3*W, h, v, n);
      chk(n == 0, "R1 quiet without start", n, 0);
   endtask

   task automatic t_unknown();
      int h, n; logic [2:0] v;
      stat = 8'h00;
      kick();
      watch(4*W, h, v, n);
      chk(h == 2*W, "R2 first expiry edge", h, 2*W);
      chk(v == 3'b010, "R6 bus reset alone", int'(v), 2);
      chk(n == 1, "R9 one pulse then idle", n, 1);
   endtask

   task automatic t_fault(input logic [7:0] s);
      int h, n; logic [2:0] v;
      stat = s;
      kick();
      watch(3*W, h, v, n);
      chk(h == 2*W && v == 3'b100, "R4 fault outcome", int'(v), 4);
      chk(n == 1, "R4 single fault pulse", n, 1);
   endtask

   task automatic t_extend(input logic [7:0] s, input logic [7:0] s_late);
      int h, n; logic [2:0] v;
      stat = s;
      kick();
      watch(2*W, h, v, n);
      chk(n == 0, "R5 extension, no outcome", n, 0);
      stat = s_late;
      watch(2*W, h, v, n);
      chk(h == W, "R5 extension length", h, W);
      chk(v == 3'b101, "R7 final error with PIO retry", int'(v), 5);
      chk(n == 1, "R7 single final pulse", n, 1);
   endtask

   task automatic t_early(input logic [7:0] s);
      int h, n; logic [2:0] v;
      stat = s;
      kick();
      watch(4*W, h, v, n);
      chk(n == 0, "R3 premature expiries extend", n, 0);
      stat = 8'h00;
      watch(2*W, h, v, n);
      chk(h == W && v == 3'b010, "R3 extension kept, reset follows", int'(v), 2);
   endtask

   task automatic t_cancel();
      int h, n; logic [2:0] v;
      stat = 8'h00;
      kick();
      watch(W, h, v, n);
      pulse_cancel(1'b0);
      watch(4*W, h, v, n);
      chk(n == 0, "R8 cancel disarms", n, 0);
      pulse_cancel(1'b1);
      watch(4*W, h, v, n);
      chk(n == 0, "R8 cancel wins over start", n, 0);
      stat = 8'h01;
      kick();
      watch(2*W + 2, h, v, n);
      pulse_cancel(1'b0);
      stat = 8'h00;
      kick();
      watch(3*W, h, v, n);
      chk(h == 2*W && v == 3'b010, "R8 fresh extension after cancel", int'(v), 2);
   endtask

   task automatic t_restart();
      int h, n; logic [2:0] v;
      stat = 8'h00;
      kick();
      watch(W, h, v, n);
      kick();
      watch(3*W, h, v, n);
      chk(h == 2*W, "R9 restart reloads full countdown", h, 2*W);
      chk(n == 1, "R9 restart yields one outcome", n, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_unknown();
      t_fault(8'h02);
      t_fault(8'h07);
      t_extend(8'h01, 8'h18);
      t_extend(8'h04, 8'h00);
      t_early(8'h18);
      t_early(8'h1A);
      t_cancel();
      t_restart();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule